// File: doc/BRIEF.md
# Machine Trap Entry and Return Sequencer

This block steers a small multi-cycle 32-bit core into and out of machine-mode trap handlers. The core raises a strobe, `chk_en`, in the one shared cycle that follows instruction decode. In that cycle the block samples six synchronous exception requests and the single external interrupt line. The interrupt line is meant to be the OR of every peripheral request. If a trap is pending, the block takes it instead of letting the instruction body run. It emits one-cycle write strobes with the new values for the exception PC, the cause register and the status bits. It then emits a single-cycle redirect pulse that carries the handler address. Vectoring is direct only: the handler address is the trap base with its two low bits cleared.

A return request works the same way in reverse. The block writes the status bits back and, a fixed number of cycles later, redirects fetch to the stored exception PC. The registers themselves live outside the block. The core feeds in their current values and commits the write strobes. There is no data stream through the block: every pin is a plain control or status signal with no handshake. The core must keep a decision from being lost by raising `chk_en` or `mret_req` only while `busy` is low. Requests that arrive while `busy` is high are dropped.

Top module: `trap_ctrl`

## Requirements
- R1: Synchronous requests arrive on `exc_req` with these bit positions: bit 0 instruction address misaligned, bit 1 illegal instruction, bit 2 breakpoint, bit 3 environment call, bit 4 load misaligned, bit 5 store misaligned. When several are set, the lowest set bit wins. Its cause code is 0, 2, 3, 11, 4 or 6 respectively, and `mcause_wdata` is that code with bit 31 clear.
- R2: The interrupt is taken only when `irq`, `meie` and `st_mie` are all high and no bit of `exc_req` is set in the same check cycle. It then writes cause 0x8000000B.
- R3: In the cycle after a trap is detected, the block raises `mepc_we`, `mcause_we` and `mstatus_we` for one cycle. `mepc_wdata` equals the `cur_pc` sampled at detection. `mstatus_mpie` takes the sampled `st_mie`, `mstatus_mie` is 0 and `mstatus_mpp` is 2'b11.
- R4: For a synchronous exception, the redirect pulse occurs 5 cycles after the detection edge when `exc_origin` is 0 or 3, 6 cycles when it is 1 (branch) and 7 cycles when it is 2 (jump). An interrupt always takes 5 cycles.
- R5: On trap entry, `redirect_pc` equals `mtvec_base` with bits 1:0 forced to zero, whatever the cause.
- R6: A return (`mret_req` while idle, with no trap taken in that cycle) redirects to `mepc_cur` 8 cycles after the request edge. The cycle after the request edge has `mstatus_we` high with `mstatus_mie` = the sampled `st_mpie`, `mstatus_mpie` = 1 and `mstatus_mpp` = 2'b11. Neither `mepc_we` nor `mcause_we` is raised.
- R7: `exc_req` and `irq` have no effect unless `chk_en` is high. `chk_en` and `mret_req` have no effect while `busy` is high. If a trap is detected in the same cycle as `mret_req`, the trap wins.
- R8: After reset, `busy`, `redirect_valid` and all write strobes are low.
- R9: `redirect_valid` is a single-cycle pulse. `busy` is high from the cycle after detection through the redirect cycle, and low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | Shared post-decode check cycle strobe |
| exc_req | input | 6 | Synchronous exception requests (bit map in R1) |
| exc_origin | input | 2 | Kind of the checked instruction: 0 plain, 1 branch, 2 jump |
| irq | input | 1 | OR-combined external interrupt |
| meie | input | 1 | External interrupt enable |
| st_mie | input | 1 | Current global interrupt enable |
| st_mpie | input | 1 | Current previous interrupt enable |
| cur_pc | input | 32 | PC of the instruction being checked |
| mtvec_base | input | 32 | Trap vector register value |
| mepc_cur | input | 32 | Current exception PC register value |
| mret_req | input | 1 | Trap return request |
| busy | output | 1 | Sequence in progress |
| mepc_we | output | 1 | Exception PC write strobe |
| mepc_wdata | output | 32 | Exception PC write value |
| mcause_we | output | 1 | Cause write strobe |
| mcause_wdata | output | 32 | Cause write value |
| mstatus_we | output | 1 | Status write strobe |
| mstatus_mie | output | 1 | New global interrupt enable |
| mstatus_mpie | output | 1 | New previous interrupt enable |
| mstatus_mpp | output | 2 | New previous privilege |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 32 | Fetch redirect address |

## Verification
A wrong priority decision or a stale snapshot shows up at once: the cause value and status bits are wrong in the cycle after detection, one edge later. A corrupted countdown shows up only at the redirect pulse, as an early, late, missing or doubled pulse. That can be up to eight cycles after the request, so every vector counts the cycles to the pulse rather than just waiting for it. A wrongly held `busy` state shows up as a swallowed or duplicated write strobe when a second request is presented during a sequence.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int NREQ = 6;

  typedef enum logic [1:0] {
    ORG_PLAIN  = 2'd0,
    ORG_BRANCH = 2'd1,
    ORG_JUMP   = 2'd2,
    ORG_SPARE  = 2'd3
  } origin_e;

  typedef struct packed {
    logic       take;
    logic       is_irq;
    logic [3:0] code;
  } verdict_t;

  localparam logic [3:0] CODE_EXT_IRQ = 4'd11;

  // request bit index -> cause code; index order is also priority order
  function automatic logic [3:0] code_of(input int idx);
    case (idx)
      0:       code_of = 4'd0;
      1:       code_of = 4'd2;
      2:       code_of = 4'd3;
      3:       code_of = 4'd11;
      4:       code_of = 4'd4;
      default: code_of = 4'd6;
    endcase
  endfunction
endpackage

// File: rtl/trap_prio.sv
module trap_prio
  import trap_pkg::*;
#(
  parameter int N = NREQ
) (
  input  logic [N-1:0] req,
  input  logic         irq,
  input  logic         irq_en,
  input  logic         glb_en,
  output verdict_t     verdict
);
  always_comb begin
    verdict = '0;
    if (|req) begin
      verdict.take = 1'b1;
      for (int i = N - 1; i >= 0; i--) begin
        if (req[i]) verdict.code = code_of(i);
      end
    end else if (irq && irq_en && glb_en) begin
      verdict.take   = 1'b1;
      verdict.is_irq = 1'b1;
      verdict.code   = CODE_EXT_IRQ;
    end
  end
endmodule

// File: rtl/trap_lat.sv
module trap_lat
  import trap_pkg::*;
#(
  parameter int CW         = 4,
  parameter int LAT_PLAIN  = 5,
  parameter int LAT_BRANCH = 6,
  parameter int LAT_JUMP   = 7,
  parameter int LAT_RET    = 8
) (
  input  logic          is_ret,
  input  logic          is_irq,
  input  origin_e       origin,
  output logic [CW-1:0] lat
);
  always_comb begin
    if (is_ret)      lat = CW'(LAT_RET);
    else if (is_irq) lat = CW'(LAT_PLAIN);
    else begin
      case (origin)
        ORG_BRANCH: lat = CW'(LAT_BRANCH);
        ORG_JUMP:   lat = CW'(LAT_JUMP);
        default:    lat = CW'(LAT_PLAIN);
      endcase
    end
  end
endmodule

// File: rtl/trap_seq.sv
module trap_seq #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] lat,
  output logic          busy,
  output logic          fire,
  output logic          first
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      first <= 1'b0;
    end else begin
      first <= start && (cnt_q == '0);
      if (start && cnt_q == '0) cnt_q <= lat;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
  assign fire = (cnt_q == CW'(1));

  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire); // R9
  AST_FIRE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !start |=> !busy); // R9
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int LAT_PLAIN  = 5,
  parameter int LAT_BRANCH = 6,
  parameter int LAT_JUMP   = 7,
  parameter int LAT_RET    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chk_en,
  input  logic [5:0]      exc_req,
  input  logic [1:0]      exc_origin,
  input  logic            irq,
  input  logic            meie,
  input  logic            st_mie,
  input  logic            st_mpie,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] mtvec_base,
  input  logic [XLEN-1:0] mepc_cur,
  input  logic            mret_req,
  output logic            busy,
  output logic            mepc_we,
  output logic [XLEN-1:0] mepc_wdata,
  output logic            mcause_we,
  output logic [XLEN-1:0] mcause_wdata,
  output logic            mstatus_we,
  output logic            mstatus_mie,
  output logic            mstatus_mpie,
  output logic [1:0]      mstatus_mpp,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc
);
  localparam int LAT_A   = (LAT_PLAIN > LAT_BRANCH) ? LAT_PLAIN : LAT_BRANCH;
  localparam int LAT_B   = (LAT_JUMP > LAT_RET) ? LAT_JUMP : LAT_RET;
  localparam int LAT_MAX = (LAT_A > LAT_B) ? LAT_A : LAT_B;
  localparam int CW      = $clog2(LAT_MAX + 1);
  localparam logic [XLEN-1:0] BASE_MASK = ~XLEN'(3);

  verdict_t        verdict;
  logic            go_entry, go_ret, start, fire, first;
  logic [CW-1:0]   lat;
  logic            ret_q, irq_q, mie_q, mpie_q;
  logic [3:0]      code_q;
  logic [XLEN-1:0] pc_q, target_q;

  trap_prio #(.N(NREQ)) u_prio (
    .req    (exc_req),
    .irq    (irq),
    .irq_en (meie),
    .glb_en (st_mie),
    .verdict(verdict)
  );

  assign go_entry = chk_en && !busy && verdict.take;
  assign go_ret   = mret_req && !busy && !go_entry;
  assign start    = go_entry || go_ret;

  trap_lat #(
    .CW(CW), .LAT_PLAIN(LAT_PLAIN), .LAT_BRANCH(LAT_BRANCH),
    .LAT_JUMP(LAT_JUMP), .LAT_RET(LAT_RET)
  ) u_lat (
    .is_ret(go_ret),
    .is_irq(verdict.is_irq),
    .origin(origin_e'(exc_origin)),
    .lat   (lat)
  );

  trap_seq #(.CW(CW)) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .lat  (lat),
    .busy (busy),
    .fire (fire),
    .first(first)
  );

  // snapshot of everything the sequence will emit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_q    <= 1'b0;
      irq_q    <= 1'b0;
      mie_q    <= 1'b0;
      mpie_q   <= 1'b0;
      code_q   <= '0;
      pc_q     <= '0;
      target_q <= '0;
    end else if (start) begin
      ret_q    <= go_ret;
      irq_q    <= verdict.is_irq && go_entry;
      mie_q    <= st_mie;
      mpie_q   <= st_mpie;
      code_q   <= verdict.code;
      pc_q     <= cur_pc;
      target_q <= go_ret ? mepc_cur : (mtvec_base & BASE_MASK);
    end
  end

  assign mepc_we        = first && !ret_q;
  assign mcause_we      = first && !ret_q;
  assign mstatus_we     = first;
  assign mepc_wdata     = pc_q;
  assign mcause_wdata   = {irq_q, {(XLEN-5){1'b0}}, code_q};
  assign mstatus_mie    = ret_q ? mpie_q : 1'b0;
  assign mstatus_mpie   = ret_q ? 1'b1 : mie_q;
  assign mstatus_mpp    = 2'b11;
  assign redirect_valid = fire;
  assign redirect_pc    = target_q;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    mcause_we && mcause_wdata[XLEN-1] |-> $past(meie && st_mie && exc_req == '0)); // R2
  AST_ENTRY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    mepc_we |-> mstatus_we && !mstatus_mie && mstatus_mpp == 2'b11); // R3
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid && !ret_q |-> redirect_pc[1:0] == 2'b00); // R5
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !mstatus_we); // R7
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mstatus_we |=> !mstatus_we); // R3
endmodule

// File: tb/trap_ctrl_bench.sv
module trap_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        chk_en, irq, meie, st_mie, st_mpie, mret_req;
  logic [5:0]  exc_req;
  logic [1:0]  exc_origin;
  logic [31:0] cur_pc, mtvec_base, mepc_cur;
  logic        busy, mepc_we, mcause_we, mstatus_we, mstatus_mie, mstatus_mpie;
  logic [1:0]  mstatus_mpp;
  logic [31:0] mepc_wdata, mcause_wdata, redirect_pc;
  logic        redirect_valid;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  trap_ctrl u_trap_ctrl (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .exc_req(exc_req),
    .exc_origin(exc_origin), .irq(irq), .meie(meie), .st_mie(st_mie),
    .st_mpie(st_mpie), .cur_pc(cur_pc), .mtvec_base(mtvec_base),
    .mepc_cur(mepc_cur), .mret_req(mret_req), .busy(busy),
    .mepc_we(mepc_we), .mepc_wdata(mepc_wdata), .mcause_we(mcause_we),
    .mcause_wdata(mcause_wdata), .mstatus_we(mstatus_we),
    .mstatus_mie(mstatus_mie), .mstatus_mpie(mstatus_mpie),
    .mstatus_mpp(mstatus_mpp), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc)
  );

  typedef struct packed {
    logic [5:0] req;
    logic       irq;
    logic       ien;
    logic       mie;
    logic [1:0] org;
    logic       take;
    logic       is_irq;
    logic [3:0] code;
    logic [3:0] lat;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{6'b000001, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 4'd0,  4'd5},
    '{6'b000010, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 4'd2,  4'd6},
    '{6'b000100, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 4'd3,  4'd7},
    '{6'b001000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 4'd11, 4'd5},
    '{6'b010000, 1'b0, 1'b0, 1'b1, 2'd3, 1'b1, 1'b0, 4'd4,  4'd5},
    '{6'b100000, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 4'd6,  4'd6},
    '{6'b111111, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 4'd0,  4'd5},
    '{6'b111110, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 4'd2,  4'd7},
    '{6'b110000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 4'd4,  4'd5},
    '{6'b101000, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 4'd11, 4'd5},
    '{6'b001100, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 4'd3,  4'd6},
    '{6'b000000, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 4'd11, 4'd5},
    '{6'b000000, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 4'd0,  4'd0},
    '{6'b000000, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 4'd0,  4'd0},
    '{6'b010000, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 4'd4,  4'd5},
    '{6'b000000, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 4'd0,  4'd0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    chk_en = 0; exc_req = '0; exc_origin = '0; irq = 0; mret_req = 0;
  endtask

  // counts negedges from the one after the start edge until the redirect pulse
  task automatic wait_redirect(output int n);
    n = 1;
    while (!redirect_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_entry(input vec_t v, input logic [31:0] pc, input string tag);
    int n;
    @(negedge clk);
    chk_en = 1; exc_req = v.req; irq = v.irq; meie = v.ien; st_mie = v.mie;
    st_mpie = ~v.mie; exc_origin = v.org; cur_pc = pc;
    @(negedge clk);
    idle_inputs();
    if (!v.take) begin
      check(!mstatus_we && !mepc_we && !busy, {tag, " R2 R7 no trap"},
            {29'b0, mstatus_we, mepc_we, busy}, 32'h0);
      return;
    end
    check(mepc_we && mcause_we && mstatus_we, {tag, " R3 strobes"},
          {29'b0, mepc_we, mcause_we, mstatus_we}, 32'h7);
    check(mcause_wdata == {v.is_irq, 27'b0, v.code}, {tag, " R1 R2 cause"},
          mcause_wdata, {v.is_irq, 27'b0, v.code});
    check(mepc_wdata == pc, {tag, " R3 mepc"}, mepc_wdata, pc);
    check(mstatus_mpie == v.mie && !mstatus_mie && mstatus_mpp == 2'b11,
          {tag, " R3 status"}, {28'b0, mstatus_mpp, mstatus_mpie, mstatus_mie},
          {28'b0, 2'b11, v.mie, 1'b0});
    check(busy, {tag, " R9 busy"}, {31'b0, busy}, 32'h1);
    wait_redirect(n);
    check(n == int'(v.lat), {tag, " R4 latency"}, n, v.lat);
    check(redirect_pc == 32'h8000_0100, {tag, " R5 target"}, redirect_pc, 32'h8000_0100);
    @(negedge clk);
    check(!redirect_valid && !busy, {tag, " R9 end"}, {30'b0, redirect_valid, busy}, 32'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 0; idle_inputs(); meie = 0; st_mie = 0; st_mpie = 0;
    cur_pc = '0; mtvec_base = 32'h8000_0103; mepc_cur = '0;
    repeat (3) @(negedge clk);
    check(!busy && !redirect_valid && !mstatus_we && !mepc_we && !mcause_we,
          "R8 reset", {27'b0, busy, redirect_valid, mstatus_we, mepc_we, mcause_we}, 32'h0);
    rst_n = 1;

    for (int i = 0; i < NV; i++)
      run_entry(VEC[i], 32'h1000 + 32'(i) * 4, $sformatf("vec%0d", i));

    // R7: requests without chk_en are ignored
    @(negedge clk);
    exc_req = 6'b111111; irq = 1; meie = 1; st_mie = 1;
    @(negedge clk);
    idle_inputs();
    check(!mstatus_we && !busy, "R7 no chk_en", {30'b0, mstatus_we, busy}, 32'h0);

    // R7: check and return requests during a sequence are ignored
    @(negedge clk);
    chk_en = 1; exc_req = 6'b000010; exc_origin = 2'd2; cur_pc = 32'h44; st_mie = 1;
    @(negedge clk);
    chk_en = 1; exc_req = 6'b000001; exc_origin = 2'd0; mret_req = 1; cur_pc = 32'h88;
    @(negedge clk);
    idle_inputs();
    check(!mstatus_we, "R7 busy ignores", {31'b0, mstatus_we}, 32'h0);
    wait_redirect(n);
    check(n == 6, "R7 R4 latency kept", n, 6);
    @(negedge clk);
    check(!busy, "R9 idle after", {31'b0, busy}, 32'h0);

    // R6: return
    @(negedge clk);
    mret_req = 1; st_mpie = 1; st_mie = 0; mepc_cur = 32'h0000_2468;
    @(negedge clk);
    idle_inputs();
    check(mstatus_we && !mepc_we && !mcause_we, "R6 strobes",
          {29'b0, mstatus_we, mepc_we, mcause_we}, 32'h4);
    check(mstatus_mie && mstatus_mpie && mstatus_mpp == 2'b11, "R6 status",
          {29'b0, mstatus_mpp, mstatus_mie}, {29'b0, 2'b11, 1'b1});
    wait_redirect(n);
    check(n == 8, "R6 latency", n, 8);
    check(redirect_pc == 32'h2468, "R6 target", redirect_pc, 32'h2468);

    @(negedge clk);
    mret_req = 1; st_mpie = 0; st_mie = 1;
    @(negedge clk);
    idle_inputs();
    check(!mstatus_mie && mstatus_mpie, "R6 mpie low",
          {30'b0, mstatus_mpie, mstatus_mie}, 32'h2);
    wait_redirect(n);

    // R7: trap wins over simultaneous return
    @(negedge clk);
    chk_en = 1; exc_req = 6'b100000; exc_origin = 2'd1; mret_req = 1; cur_pc = 32'h300;
    @(negedge clk);
    idle_inputs();
    check(mepc_we && mcause_wdata == 32'd6, "R7 trap over return", mcause_wdata, 32'd6);
    wait_redirect(n);
    check(n == 6 && redirect_pc == 32'h8000_0100, "R7 R5 redirect", redirect_pc, 32'h8000_0100);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule